// File: doc/BRIEF.md
# Banked Endpoint Buffer Access Port

This block is the CPU-side way into the packet buffer RAM of a small USB device controller. The CPU uses a byte-wide special-function-register bus with an address, a write strobe, a read strobe, write data and registered read data. A bank select register decides what a shared window of seven addresses (C1h to C7h) shows. It can show the device-wide registers, or the register bank of one of five endpoints.

Every endpoint bank holds a base address for that endpoint's part of the buffer RAM, a direction bit and a buffer-full bit. A single data port at D3h moves one byte at a time between the CPU and the RAM. The RAM address is the selected endpoint's base times eight plus a shared offset register. The offset steps forward after every access that goes through. An access goes through only when the direction bit and the full bit disagree. If it is refused, no data moves and a sticky error flag is set in that endpoint's interrupt request register. Packet handling on the USB side is not part of this block.

Top module: `ebap_access_port`

## Requirements
- R1: After reset every register reads 00h, endpoint 0 is selected, and sfr_rdata is 00h.
- R2: The bank select register sits at C0h and is read/write. When its bit 7 is 1, window slots C1h..C7h are: device control, power-down, interrupt enable, interrupt request, reserved, frame number low, frame number high. All of them are plain 8-bit read/write storage.
- R3: When bit 7 of the select register is 0 and bits 2:0 hold 0..4, window slots C1h..C7h are that endpoint's: buffer control, buffer status, interrupt enable, interrupt request, base, length, reserved. The buffer control bit 7 is the direction bit and the buffer status bit 0 is the full bit.
- R4: A write to the data port at D3h with a valid endpoint selected and direction XOR full equal to 1 stores the byte at RAM address (base*8 + offset) mod 256.
- R5: A read of D3h under the same condition returns the RAM byte at that address.
- R6: A D3h access with a valid endpoint selected and direction equal to full is refused. It leaves the RAM unchanged, a read returns 00h, and bit 0 of that endpoint's interrupt request register is set.
- R7: The offset register at D2h is read/write. It increments by one (wrapping 255 to 0) after each accepted D3h access and is unchanged by a refused one.
- R8: Interrupt request bit 0 of an endpoint clears only when the CPU writes 0 to it; writing 1 leaves it as it was. Bits 7:1 are plain storage.
- R9: With endpoint number 5..7 selected, window reads return 00h and window writes are ignored. Reserved slots and unmapped addresses read 00h. A D3h access while the device bank or endpoint 5..7 is selected moves no data, returns 00h, sets no flag and leaves the offset unchanged.
- R10: sfr_rdata takes the addressed value at the clock edge that samples sfr_rd and holds it until the next read. When both strobes are high in the same cycle, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe, one access per cycle |
| sfr_rd | input | 1 | Read strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, valid the cycle after sfr_rd |

## Verification
Most internal faults show up at the ports within one access. A wrong base or offset makes a later D3h read return a byte from somewhere else. A missed offset step shifts every later byte by one place. A lost or stuck error flag shows up on the next read of the interrupt request slot. The bench first fills the whole RAM through the port, so every later data read can be compared against a bench model. A bad bank decode shows up as wrong read-back, and the next window read after a selection change exposes it.

// File: rtl/ebap_pkg.sv
package ebap_pkg;

  typedef enum logic [2:0] {
    EP_CTRL = 3'd0,
    EP_STAT = 3'd1,
    EP_IEN  = 3'd2,
    EP_IREQ = 3'd3,
    EP_BASE = 3'd4,
    EP_LEN  = 3'd5,
    EP_RSVD = 3'd6
  } ep_slot_e;

  typedef enum logic [2:0] {
    DV_CTRL = 3'd0,
    DV_PWR  = 3'd1,
    DV_IEN  = 3'd2,
    DV_IREQ = 3'd3,
    DV_RSVD = 3'd4,
    DV_FRLO = 3'd5,
    DV_FRHI = 3'd6
  } dev_slot_e;

  // buffer address before truncation to the RAM width
  function automatic logic [15:0] buf_addr(input logic [7:0] base, input logic [7:0] off);
    return ({8'h00, base} << 3) + {8'h00, off};
  endfunction

  // transfer allowed when direction and full flag disagree
  function automatic logic access_ok(input logic dir, input logic full);
    return dir ^ full;
  endfunction

endpackage

// File: rtl/ebap_ep_bank.sv
module ebap_ep_bank #(
  parameter int DIR_BIT  = 7,
  parameter int FULL_BIT = 0,
  parameter int ERR_BIT  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] slot,
  input  logic [7:0] wdata,
  input  logic       set_err,
  output logic [7:0] rd_byte,
  output logic       dir_q,
  output logic       full_q,
  output logic       err_q,
  output logic [7:0] base_q
);
  import ebap_pkg::*;

  localparam logic [7:0] ERR_MASK = 8'(1) << ERR_BIT;

  logic [7:0] ctrl_r, stat_r, ien_r, ireq_r, base_r, len_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      stat_r <= '0;
      ien_r  <= '0;
      ireq_r <= '0;
      base_r <= '0;
      len_r  <= '0;
    end else begin
      if (wr_en) begin
        case (slot)
          EP_CTRL: ctrl_r <= wdata;
          EP_STAT: stat_r <= wdata;
          EP_IEN:  ien_r  <= wdata;
          EP_IREQ: ireq_r <= (wdata & ~ERR_MASK) | (ireq_r & wdata & ERR_MASK);
          EP_BASE: base_r <= wdata;
          EP_LEN:  len_r  <= wdata;
          default: ;
        endcase
      end
      if (set_err) ireq_r[ERR_BIT] <= 1'b1;
    end
  end

  always_comb begin
    case (slot)
      EP_CTRL: rd_byte = ctrl_r;
      EP_STAT: rd_byte = stat_r;
      EP_IEN:  rd_byte = ien_r;
      EP_IREQ: rd_byte = ireq_r;
      EP_BASE: rd_byte = base_r;
      EP_LEN:  rd_byte = len_r;
      default: rd_byte = 8'h00;
    endcase
  end

  assign dir_q  = ctrl_r[DIR_BIT];
  assign full_q = stat_r[FULL_BIT];
  assign err_q  = ireq_r[ERR_BIT];
  assign base_q = base_r;

endmodule

// File: rtl/ebap_dev_bank.sv
module ebap_dev_bank (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] slot,
  input  logic [7:0] wdata,
  output logic [7:0] rd_byte
);
  import ebap_pkg::*;

  logic [7:0] ctrl_r, pwr_r, ien_r, ireq_r, frlo_r, frhi_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      pwr_r  <= '0;
      ien_r  <= '0;
      ireq_r <= '0;
      frlo_r <= '0;
      frhi_r <= '0;
    end else if (wr_en) begin
      case (slot)
        DV_CTRL: ctrl_r <= wdata;
        DV_PWR:  pwr_r  <= wdata;
        DV_IEN:  ien_r  <= wdata;
        DV_IREQ: ireq_r <= wdata;
        DV_FRLO: frlo_r <= wdata;
        DV_FRHI: frhi_r <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot)
      DV_CTRL: rd_byte = ctrl_r;
      DV_PWR:  rd_byte = pwr_r;
      DV_IEN:  rd_byte = ien_r;
      DV_IREQ: rd_byte = ireq_r;
      DV_FRLO: rd_byte = frlo_r;
      DV_FRHI: rd_byte = frhi_r;
      default: rd_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/ebap_buf_ram.sv
module ebap_buf_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/ebap_access_port.sv
module ebap_access_port #(
  parameter int         NUM_EP    = 5,
  parameter int         RAM_AW    = 8,
  parameter logic [7:0] SEL_ADDR  = 8'hC0,
  parameter logic [7:0] WIN_BASE  = 8'hC1,
  parameter logic [7:0] OFF_ADDR  = 8'hD2,
  parameter logic [7:0] DATA_ADDR = 8'hD3,
  parameter int         DIR_BIT   = 7,
  parameter int         FULL_BIT  = 0,
  parameter int         ERR_BIT   = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata
);
  import ebap_pkg::*;

  localparam int         WIN_SLOTS = 7;
  localparam logic [7:0] WIN_LAST  = WIN_BASE + 8'(WIN_SLOTS - 1);

  // bus decode
  logic       wr_cyc, rd_cyc, in_win, data_hit;
  logic [2:0] slot;
  assign wr_cyc   = sfr_wr;
  assign rd_cyc   = sfr_rd & ~sfr_wr;
  assign in_win   = (sfr_addr >= WIN_BASE) && (sfr_addr <= WIN_LAST);
  assign slot     = 3'(sfr_addr - WIN_BASE);
  assign data_hit = (sfr_addr == DATA_ADDR);

  // bank select and offset
  logic [7:0] sel_q, off_q;
  logic       dev_sel, ep_valid;
  logic [2:0] ep_idx;
  assign dev_sel  = sel_q[7];
  assign ep_valid = !sel_q[7] && (32'(sel_q[2:0]) < NUM_EP);
  assign ep_idx   = ep_valid ? sel_q[2:0] : 3'd0;

  // per-endpoint state
  logic [7:0]        ep_rd   [NUM_EP];
  logic [7:0]        ep_base [NUM_EP];
  logic [NUM_EP-1:0] ep_dir, ep_full, err_vec, err_clr;
  logic [NUM_EP-1:0] ep_wr, ep_set_err;

  // events
  logic cur_dir, cur_full, cur_ok;
  logic data_req, data_ok_ev, data_refuse_ev, ram_we, bank_none;
  logic [7:0] cur_base;

  assign cur_dir  = ep_dir[ep_idx];
  assign cur_full = ep_full[ep_idx];
  assign cur_base = ep_base[ep_idx];
  assign cur_ok   = access_ok(cur_dir, cur_full);

  assign data_req       = data_hit & (wr_cyc | rd_cyc);
  assign data_ok_ev     = data_req & ep_valid & cur_ok;
  assign data_refuse_ev = data_req & ep_valid & ~cur_ok;
  assign ram_we         = data_ok_ev & wr_cyc;
  assign bank_none      = in_win & ~dev_sel & ~ep_valid;

  generate
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      assign ep_wr[e]      = wr_cyc & in_win & ep_valid & (ep_idx == 3'(e));
      assign ep_set_err[e] = data_refuse_ev & (ep_idx == 3'(e));
      assign err_clr[e]    = ep_wr[e] & (slot == EP_IREQ) & ~sfr_wdata[ERR_BIT];

      ebap_ep_bank #(
        .DIR_BIT (DIR_BIT),
        .FULL_BIT(FULL_BIT),
        .ERR_BIT (ERR_BIT)
      ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ep_wr[e]),
        .slot   (slot),
        .wdata  (sfr_wdata),
        .set_err(ep_set_err[e]),
        .rd_byte(ep_rd[e]),
        .dir_q  (ep_dir[e]),
        .full_q (ep_full[e]),
        .err_q  (err_vec[e]),
        .base_q (ep_base[e])
      );
    end
  endgenerate

  // device bank
  logic [7:0] dev_rd;
  ebap_dev_bank u_dev (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_cyc & in_win & dev_sel),
    .slot   (slot),
    .wdata  (sfr_wdata),
    .rd_byte(dev_rd)
  );

  // buffer RAM
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]        ram_rdata;
  assign ram_addr = RAM_AW'(buf_addr(cur_base, off_q));

  ebap_buf_ram #(.AW(RAM_AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(sfr_wdata),
    .rdata(ram_rdata)
  );

  // select and offset registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= '0;
    end else begin
      if (wr_cyc && sfr_addr == SEL_ADDR) sel_q <= sfr_wdata;
      if (wr_cyc && sfr_addr == OFF_ADDR) off_q <= sfr_wdata;
      else if (data_ok_ev)                off_q <= off_q + 8'd1;
    end
  end

  // read path
  logic [7:0] rd_next;
  always_comb begin
    rd_next = 8'h00;
    if (sfr_addr == SEL_ADDR)      rd_next = sel_q;
    else if (sfr_addr == OFF_ADDR) rd_next = off_q;
    else if (data_hit)             rd_next = data_ok_ev ? ram_rdata : 8'h00;
    else if (in_win) begin
      if (dev_sel)       rd_next = dev_rd;
      else if (ep_valid) rd_next = ep_rd[ep_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sfr_rdata <= '0;
    else if (rd_cyc) sfr_rdata <= rd_next;
  end

endmodule

// File: rtl/ebap_access_port_chk.sv
module ebap_access_port_chk #(
  parameter int NUM_EP = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_ok_ev,
  input logic              data_refuse_ev,
  input logic              rd_cyc,
  input logic              bank_none,
  input logic [2:0]        ep_idx,
  input logic [7:0]        off_q,
  input logic [7:0]        sfr_rdata,
  input logic [NUM_EP-1:0] err_vec,
  input logic [NUM_EP-1:0] err_clr
);

  p_off_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok_ev |=> off_q == $past(off_q) + 8'd1);

  p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_refuse_ev |=> $stable(off_q));

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_refuse_ev |=> err_vec[$past(ep_idx)]);

  p_refuse_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_refuse_ev && rd_cyc) |=> sfr_rdata == 8'h00);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_vec & $past(err_vec & ~err_clr)) == $past(err_vec & ~err_clr)));

  p_none_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_none && rd_cyc) |=> sfr_rdata == 8'h00);

endmodule

bind ebap_access_port ebap_access_port_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .data_ok_ev    (data_ok_ev),
  .data_refuse_ev(data_refuse_ev),
  .rd_cyc        (rd_cyc),
  .bank_none     (bank_none),
  .ep_idx        (ep_idx),
  .off_q         (off_q),
  .sfr_rdata     (sfr_rdata),
  .err_vec       (err_vec),
  .err_clr       (err_clr)
);

// File: tb/sim_ebap_access_port.sv
`timescale 1ns/1ps
module sim_ebap_access_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic       sfr_wr = 1'b0;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ebap_access_port u0 (.*);

  // bench model
  logic [7:0] m_sel, m_off;
  logic [7:0] m_ep  [5][6];
  logic [7:0] m_dev [7];
  logic [7:0] m_ram [256];

  function automatic logic [7:0] exp_addr(input logic [7:0] base, input logic [7:0] off);
    logic [10:0] wide;
    wide = base * 11'd8 + off;
    return wide[7:0];
  endfunction

  function automatic bit m_epok();
    return (m_sel[7] == 1'b0) && (m_sel[2:0] <= 3'd4);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    int e;
    e = int'(m_sel[2:0]);
    if (a == 8'hC0) m_sel = d;
    else if (a == 8'hD2) m_off = d;
    else if (a == 8'hD3) begin
      if (m_epok()) begin
        if (m_ep[e][0][7] != m_ep[e][1][0]) begin
          m_ram[exp_addr(m_ep[e][4], m_off)] = d;
          m_off = m_off + 8'd1;
        end else m_ep[e][3][0] = 1'b1;
      end
    end else if (a >= 8'hC1 && a <= 8'hC7) begin
      int idx;
      idx = int'(a - 8'hC1);
      if (m_sel[7]) begin
        if (idx != 4) m_dev[idx] = d;
      end else if (m_epok() && idx != 6) begin
        if (idx == 3) m_ep[e][3] = {d[7:1], m_ep[e][3][0] & d[0]};
        else m_ep[e][idx] = d;
      end
    end
  endtask

  task automatic m_read(input logic [7:0] a, output logic [7:0] v);
    int e;
    e = int'(m_sel[2:0]);
    v = 8'h00;
    if (a == 8'hC0) v = m_sel;
    else if (a == 8'hD2) v = m_off;
    else if (a == 8'hD3) begin
      if (m_epok()) begin
        if (m_ep[e][0][7] != m_ep[e][1][0]) begin
          v = m_ram[exp_addr(m_ep[e][4], m_off)];
          m_off = m_off + 8'd1;
        end else m_ep[e][3][0] = 1'b1;
      end
    end else if (a >= 8'hC1 && a <= 8'hC7) begin
      int idx;
      idx = int'(a - 8'hC1);
      if (m_sel[7]) v = m_dev[idx];
      else if (m_epok() && idx != 6) v = m_ep[e][idx];
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    logic [7:0] v;
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    @(negedge clk);
    sfr_rd = 1'b0;
    m_read(a, v);
    check(tag, sfr_rdata, v);
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'hD3) return "R5/R6";
    if (a == 8'hD2) return "R7";
    if (a >= 8'hC1 && a <= 8'hC7) return m_sel[7] ? "R2" : (m_epok() ? "R3" : "R9");
    return "R9";
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED_0042));
    m_sel = 0; m_off = 0;
    for (int i = 0; i < 5; i++) for (int j = 0; j < 6; j++) m_ep[i][j] = 0;
    for (int i = 0; i < 7; i++) m_dev[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 rdata", sfr_rdata, 8'h00);
    do_rd(8'hC0, "R1 sel");
    do_rd(8'hD2, "R1 off");
    for (int a = 8'hC1; a <= 8'hC7; a++) do_rd(8'(a), "R1 ep0");

    // fill RAM: dir=1 full=0 so writes pass; R7 wrap after 256
    do_wr(8'hC1, 8'h80);
    do_wr(8'hC2, 8'h00);
    for (int i = 0; i < 256; i++) do_wr(8'hD3, 8'($urandom));
    do_rd(8'hD2, "R7 wrap");
    do_rd(8'hC4, "R4 no flag");

    // R4/R5 base truncation: base 25h, offset 10h -> 38h
    do_wr(8'hC1, 8'h00);
    do_wr(8'hC2, 8'h01);
    do_wr(8'hC5, 8'h25);
    do_wr(8'hD2, 8'h10);
    do_rd(8'hD3, "R5 addr 38h");
    do_rd(8'hD3, "R5 next byte");
    do_rd(8'hD2, "R7 step");
    do_wr(8'hC1, 8'h80); do_wr(8'hC2, 8'h00);
    do_wr(8'hD3, 8'hA5);
    do_wr(8'hD2, 8'h12);
    do_wr(8'hC1, 8'h00); do_wr(8'hC2, 8'h01);
    do_rd(8'hD3, "R4 write back");

    // R6 refused read and write
    do_wr(8'hC2, 8'h00);
    do_rd(8'hD3, "R6 refused read");
    do_rd(8'hC4, "R6 flag set");
    do_wr(8'hC1, 8'h80); do_wr(8'hC2, 8'h01);
    do_wr(8'hD3, 8'h3C);
    do_rd(8'hD2, "R7 hold on refuse");

    // R8 flag clear semantics
    do_wr(8'hC4, 8'hFF);
    do_rd(8'hC4, "R8 write 1 keeps");
    do_wr(8'hC4, 8'h00);
    do_rd(8'hC4, "R8 write 0 clears");

    // R3 reserved slot
    do_wr(8'hC7, 8'h77);
    do_rd(8'hC7, "R3 reserved");

    // R9 endpoint 5
    do_wr(8'hC0, 8'h05);
    do_wr(8'hC1, 8'h55);
    do_rd(8'hC1, "R9 ep5 read");
    do_rd(8'hD3, "R9 ep5 data");
    do_rd(8'hD2, "R9 off kept");
    do_rd(8'h9A, "R9 unmapped");

    // R2 device bank
    do_wr(8'hC0, 8'h80);
    for (int a = 8'hC1; a <= 8'hC7; a++) do_wr(8'(a), 8'(a * 3));
    for (int a = 8'hC1; a <= 8'hC7; a++) do_rd(8'(a), "R2 dev");
    do_rd(8'hD3, "R9 dev data");

    // R10 hold and write priority
    do_wr(8'hC0, 8'h00);
    do_rd(8'hC0, "R10 read");
    held = sfr_rdata;
    repeat (3) @(negedge clk);
    check("R10 hold", sfr_rdata, held);
    @(negedge clk);
    sfr_addr = 8'hD2; sfr_wdata = 8'h44; sfr_wr = 1'b1; sfr_rd = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_rd = 1'b0;
    m_write(8'hD2, 8'h44);
    check("R10 wr wins rdata", sfr_rdata, held);
    do_rd(8'hD2, "R10 wr wins off");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [7:0] a;
      r = int'($urandom % 10);
      case (r)
        0: do_wr(8'hC0, ($urandom % 6 == 0) ? 8'($urandom) : 8'($urandom % 5));
        1, 2: do_wr(8'(8'hC1 + $urandom % 7), 8'($urandom));
        3: begin a = 8'(8'hC1 + $urandom % 7); do_rd(a, tag_of(a)); end
        4: do_wr(8'hD2, 8'($urandom));
        5: begin
             a = ($urandom % 2 == 0) ? 8'hD2 : 8'($urandom);
             do_rd(a, tag_of(a));
           end
        6, 7: do_wr(8'hD3, 8'($urandom));
        default: do_rd(8'hD3, "R5/R6");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule